// File: doc/BRIEF.md
# Output DC Offset Test Window Monitor

This block times an output DC offset test on a group of amplifier channels. Each channel provides a digital comparator flag. The flag is high while that channel's output offset is above the detection threshold. The test runs over a window that is defined entirely by the host's bus reads. The window opens when the host sets the offset-enable control, or at the previous read while the control is still set. It closes at the current read. At that read the per-channel verdicts are latched into the status outputs.

A channel is reported as offset only if its comparator flag stays high on every cycle of the window. A short-circuit protection event on any channel during the window voids the whole test, and every channel then reports clean. A read that closes a window immediately opens the next one while the enable stays set. The status therefore always describes the previous window.

Top module: `ofsw_monitor`

## Requirements
- R1: After reset, `ofs_flag` is all zero and `test_active` is 0.
- R2: `test_active` becomes 1 on the cycle after `ofs_en` rises. It becomes 0 on the cycle after a cycle with `ofs_en` low. A read while `ofs_en` stays high keeps it at 1.
- R3: A window cycle is a cycle in which `test_active` is 1 and `ofs_en` is 1. On a read in a window cycle, `ofs_flag[i]` (bit i belongs to channel i) is set to 1 if `cmp_hi[i]` was 1 on every window cycle since the window opened, counting the read cycle itself.
- R4: If `cmp_hi[i]` is 0 on any window cycle, including the read cycle, `ofs_flag[i]` is 0 after that read.
- R5: If any bit of `prot_trip` is 1 on any window cycle, including the read cycle, all `ofs_flag` bits are 0 after that read.
- R6: A read on a cycle that is not a window cycle sets all `ofs_flag` bits to 0. This covers a read on the same cycle as the enable rising, which is an empty window, and a read with `ofs_en` low.
- R7: A read starts a fresh window. The next verdict depends only on the cycles after that read.
- R8: `ofs_flag` changes only on the cycle after a read (`rd_done` = 1). At all other times it holds its value.
- R9: Channels are judged independently. The comparator state of one channel never changes another channel's bit, except through the shared void of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ofs_en | input | 1 | Offset test enable level from the control register |
| rd_done | input | 1 | One-cycle pulse when a host status read completes |
| cmp_hi | input | NCH | Per-channel flag: output offset above threshold |
| prot_trip | input | NCH | Per-channel short-circuit protection active |
| ofs_flag | output | NCH | Latched per-channel offset verdicts |
| test_active | output | 1 | Offset window is running |

## Verification
Every verdict is registered once. The bits of `ofs_flag` are due on the first cycle after the clock edge that sees `rd_done`. `test_active` follows a change of `ofs_en` by exactly one edge. The bench drives its inputs on the falling edge and samples one falling edge later. There, on every cycle, it compares the outputs with a behavioural model. The model counts window cycles, high-comparator cycles per channel and protection cycles. The directed checks are placed on that same following falling edge.

// File: rtl/ofsw_pkg.sv
package ofsw_pkg;

  // verdict of one channel at the closing read: no earlier drop, still high now
  function automatic logic chan_verdict(input logic dropped, input logic cmp_now);
    return !dropped && cmp_now;
  endfunction

  // a new window starts on an enable rise or on any read
  function automatic logic open_event(input logic en, input logic en_q, input logic rd);
    return (en && !en_q) || rd;
  endfunction

endpackage

// File: rtl/ofsw_window.sv
module ofsw_window
  import ofsw_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           rd_done,
  input  logic [NCH-1:0] prot,
  output logic           win,
  output logic           restart,
  output logic           void_now,
  output logic           active
);
  logic en_q;
  logic active_q;
  logic void_q;
  logic prot_any;

  assign prot_any = |prot;
  assign restart  = open_event(en, en_q, rd_done);
  assign win      = active_q && en;
  assign void_now = void_q || (win && prot_any);
  assign active   = active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      active_q <= 1'b0;
      void_q   <= 1'b0;
    end else begin
      en_q     <= en;
      active_q <= en && (active_q || restart);
      if (restart)               void_q <= 1'b0;
      else if (win && prot_any)  void_q <= 1'b1;
    end
  end
endmodule

// File: rtl/ofsw_chan.sv
module ofsw_chan
  import ofsw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic win,
  input  logic restart,
  input  logic cmp,
  output logic pass
);
  logic dropped_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            dropped_q <= 1'b0;
    else if (restart)      dropped_q <= 1'b0;
    else if (win && !cmp)  dropped_q <= 1'b1;
  end

  assign pass = chan_verdict(dropped_q, cmp);
endmodule

// File: rtl/ofsw_latch.sv
module ofsw_latch #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rd_done,
  input  logic           win,
  input  logic           void_now,
  input  logic [NCH-1:0] pass,
  output logic [NCH-1:0] flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags <= '0;
    else if (rd_done)  flags <= (win && !void_now) ? pass : '0;
  end
endmodule

// File: rtl/ofsw_monitor.sv
module ofsw_monitor #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ofs_en,
  input  logic           rd_done,
  input  logic [NCH-1:0] cmp_hi,
  input  logic [NCH-1:0] prot_trip,
  output logic [NCH-1:0] ofs_flag,
  output logic           test_active
);
  logic           win;
  logic           restart;
  logic           void_now;
  logic [NCH-1:0] pass;

  ofsw_window #(.NCH(NCH)) u_win (
    .clk(clk), .rst_n(rst_n), .en(ofs_en), .rd_done(rd_done), .prot(prot_trip),
    .win(win), .restart(restart), .void_now(void_now), .active(test_active)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    ofsw_chan u_ch (
      .clk(clk), .rst_n(rst_n), .win(win), .restart(restart),
      .cmp(cmp_hi[g]), .pass(pass[g])
    );
  end

  ofsw_latch #(.NCH(NCH)) u_lat (
    .clk(clk), .rst_n(rst_n), .rd_done(rd_done), .win(win),
    .void_now(void_now), .pass(pass), .flags(ofs_flag)
  );
endmodule

// File: rtl/ofsw_checker.sv
module ofsw_checker #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ofs_en,
  input logic           rd_done,
  input logic [NCH-1:0] cmp_hi,
  input logic [NCH-1:0] prot_trip,
  input logic [NCH-1:0] ofs_flag,
  input logic           test_active,
  input logic           win
);
  p_rise_act_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ofs_en && !test_active) |=> test_active);

  p_off_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ofs_en |=> !test_active);

  p_drop_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && win) |=> ((ofs_flag & ~$past(cmp_hi)) == '0));

  p_prot_void_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && win && (|prot_trip)) |=> (ofs_flag == '0));

  p_empty_win_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !win) |=> (ofs_flag == '0));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_done |=> $stable(ofs_flag));
endmodule

bind ofsw_monitor ofsw_checker #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ofs_en(ofs_en), .rd_done(rd_done),
  .cmp_hi(cmp_hi), .prot_trip(prot_trip), .ofs_flag(ofs_flag),
  .test_active(test_active), .win(win)
);

// File: tb/sim_ofsw_monitor.sv
module sim_ofsw_monitor;
  localparam int NCH = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           ofs_en = 1'b0;
  logic           rd_done = 1'b0;
  logic [NCH-1:0] cmp_hi = '0;
  logic [NCH-1:0] prot_trip = '0;
  logic [NCH-1:0] ofs_flag;
  logic           test_active;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  ofsw_monitor #(.NCH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .ofs_en(ofs_en), .rd_done(rd_done),
    .cmp_hi(cmp_hi), .prot_trip(prot_trip), .ofs_flag(ofs_flag),
    .test_active(test_active)
  );

  // behavioural reference: counts cycles instead of sticky bits
  int m_wc;
  int m_hc [NCH];
  int m_pc;
  bit m_act;
  bit m_enp;
  bit [NCH-1:0] m_flag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_wc = 0; m_pc = 0; m_act = 0; m_enp = 0; m_flag = '0;
      foreach (m_hc[i]) m_hc[i] = 0;
    end else begin
      bit inwin, rose;
      inwin = m_act && ofs_en;
      rose  = ofs_en && !m_enp;
      if (inwin) begin
        m_wc++;
        if (prot_trip != 0) m_pc++;
        for (int i = 0; i < NCH; i++) if (cmp_hi[i]) m_hc[i]++;
      end
      if (rd_done) begin
        for (int i = 0; i < NCH; i++)
          m_flag[i] = inwin && (m_pc == 0) && (m_hc[i] == m_wc);
      end
      if (rd_done || rose) begin
        m_wc = 0; m_pc = 0;
        foreach (m_hc[i]) m_hc[i] = 0;
      end
      m_act = ofs_en && (m_act || rd_done || rose);
      m_enp = ofs_en;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // compare with the model on every falling edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      check(cur_req, int'(ofs_flag), int'(m_flag));
      check(cur_req, int'(test_active), int'(m_act));
    end
  end

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic read_once();
    rd_done = 1'b1; tick(); rd_done = 1'b0;
  endtask

  initial begin
    tick(3);
    check("R1", int'(ofs_flag), 0);
    check("R1", int'(test_active), 0);
    rst_n = 1'b1;
    tick();

    // R2: activity follows enable by one edge
    cur_req = "R2";
    cmp_hi = 4'hF;
    ofs_en = 1'b1; tick();
    check("R2", int'(test_active), 1);
    ofs_en = 1'b0; tick();
    check("R2", int'(test_active), 0);

    // R3: all channels high for a full window
    cur_req = "R3";
    ofs_en = 1'b1; tick(5);
    read_once();
    check("R3", int'(ofs_flag), 4'hF);
    check("R2", int'(test_active), 1);

    // R4: ch1 drops mid-window, ch2 drops on the read cycle
    cur_req = "R4";
    tick(2);
    cmp_hi = 4'b1101; tick(); cmp_hi = 4'hF; tick(2);
    cmp_hi = 4'b1011; read_once(); cmp_hi = 4'hF;
    check("R4", int'(ofs_flag), 4'b1001);

    // R5: a protection pulse voids everything, also on the read cycle
    cur_req = "R5";
    tick(2);
    prot_trip = 4'b0100; tick(); prot_trip = '0; tick(2);
    read_once();
    check("R5", int'(ofs_flag), 0);
    tick(3);
    read_once();
    check("R7", int'(ofs_flag), 4'hF);
    tick(2);
    prot_trip = 4'b0001; read_once(); prot_trip = '0;
    check("R5", int'(ofs_flag), 0);

    // R7: after a read, an earlier drop no longer counts
    cur_req = "R7";
    tick(3);
    cmp_hi = 4'b0111; read_once(); cmp_hi = 4'hF;
    check("R4", int'(ofs_flag), 4'b0111);
    tick(4);
    read_once();
    check("R7", int'(ofs_flag), 4'hF);

    // R8: no read, no change even if inputs toggle
    cur_req = "R8";
    cmp_hi = 4'h0; prot_trip = 4'hF; tick(4);
    check("R8", int'(ofs_flag), 4'hF);
    cmp_hi = 4'hF; prot_trip = '0;

    // R6: empty window (read on the enable rise) and read with enable low
    cur_req = "R6";
    ofs_en = 1'b0; tick(2);
    check("R8", int'(ofs_flag), 4'hF);
    ofs_en = 1'b1; read_once();
    check("R6", int'(ofs_flag), 0);
    tick(3); read_once();
    check("R6", int'(ofs_flag), 4'hF);
    ofs_en = 1'b0; read_once();
    check("R6", int'(ofs_flag), 0);

    // R9: independent channels under random stimulus
    cur_req = "R9";
    ofs_en = 1'b1; tick();
    for (int n = 0; n < 4000; n++) begin
      ofs_en    = ($urandom_range(0, 39) != 0);
      rd_done   = ($urandom_range(0, 7) == 0);
      for (int i = 0; i < NCH; i++) begin
        cmp_hi[i]    = ($urandom_range(0, 2 + 10 * i) != 0);
        prot_trip[i] = ($urandom_range(0, 199) == 0);
      end
      tick();
    end
    rd_done = 1'b0;
    tick(2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5 * 100000);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule